// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge and Completion Interface

This block is the guest-facing side of a per-CPU virtual interrupt controller. It fronts a small table of list entries, each holding an interrupt ID, a priority, a group bit (0 or 1), pending and active flags, a hardware-link flag and a physical ID. A hypervisor fills the table through a load port. The guest uses a small register port. For each group it can acknowledge the best pending interrupt, signal end of interrupt (EOI), or look at the best pending interrupt without changing anything. A shared deactivate register is also provided.

An acknowledge marks the chosen entry active and sets one bit in an active-priorities vector, indexed by the entry's priority. An EOI clears the bit of the most recently acknowledged interrupt that is still running; this is the priority drop. A mode input selects what happens next. With mode 0, the EOI also deactivates the entry. With mode 1, the entry stays active until its ID is written to the deactivate register. When a hardware-linked entry is deactivated, the block pulses a physical-deactivate output that carries the entry's physical ID.

A small controller serialises the work. In IDLE it accepts a request and moves to ACK, EOI, HPP or DIR according to the register select. Each of those states does its work in one cycle and returns to IDLE. A reserved select value stays in IDLE. A read result appears with `rsp_valid` on the second clock edge after the request is accepted.

Top module: `virq_cpu_if`

## Requirements
- R1: After reset, every list entry is empty, `act_prio` is zero, `rsp_valid`, `pdeact_valid` and `eoi_err` are low, and `req_ready` is high.
- R2: An acknowledge returns, in `rsp_data[9:0]`, the ID of the pending entry of the addressed group with the lowest priority value. Among entries with equal priority, the lowest index wins. The entry becomes active and no longer pending, and bit `prio` of `act_prio` is set.
- R3: An acknowledge returns the spurious ID 1023 when the addressed group has no pending entry.
- R4: An acknowledge returns 1023 when the other group has a pending entry with a strictly lower priority value than the best entry of the addressed group.
- R5: An acknowledge returns 1023 and changes no state when the best candidate's priority value is not strictly below the lowest set index of `act_prio`.
- R6: A highest-pending read returns the ID that R2 would select, or 1023 when the group has no pending entry, and changes no state.
- R7: An EOI whose group and ID match the most recent acknowledge that has not yet completed clears that interrupt's `act_prio` bit. Completions therefore follow reverse acknowledge order (last in, first out).
- R8: With `eoi_mode`=0, an accepted EOI also deactivates the entry. If the entry is hardware-linked, `pdeact_valid` pulses for one cycle with `pdeact_id` set to the entry's physical ID.
- R9: With `eoi_mode`=1, an accepted EOI only drops the priority. The entry stays active and no physical-deactivate pulse is sent.
- R10: With `eoi_mode`=1, a write to the deactivate register deactivates the active entry whose ID matches, in any order, and a hardware-linked entry pulses `pdeact_valid`/`pdeact_id`. A write that matches no active entry, or any deactivate write while `eoi_mode`=0, has no effect.
- R11: An EOI is rejected in three cases: nothing is outstanding, the group of the outstanding interrupt differs from the register's group, or the ID differs. A rejected EOI pulses `eoi_err` for one cycle and changes no state.
- R12: Register select codes on `req_sel`: 000 acknowledge group 0, 001 EOI group 0, 010 highest-pending group 0, 100/101/110 the same three for group 1, 011 deactivate, 111 reserved. A request is taken only when `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eoi_mode | input | 1 | 0: EOI drops priority and deactivates; 1: EOI drops priority only |
| lr_we | input | 1 | List-entry write strobe |
| lr_idx | input | 2 | Entry index to write |
| lr_id | input | 10 | Virtual interrupt ID |
| lr_prio | input | 5 | Priority, lower value is more urgent |
| lr_grp | input | 1 | Group bit |
| lr_pend | input | 1 | Pending flag |
| lr_act | input | 1 | Active flag |
| lr_hw | input | 1 | Hardware-linked flag |
| lr_pid | input | 10 | Physical interrupt ID |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_sel | input | 3 | Register select (see R12) |
| req_wdata | input | 10 | ID for EOI and deactivate writes |
| rsp_valid | output | 1 | Read result strobe |
| rsp_data | output | 10 | Read result (ID or 1023) |
| pdeact_valid | output | 1 | Physical-deactivate strobe |
| pdeact_id | output | 10 | Physical ID being deactivated |
| eoi_err | output | 1 | Rejected-EOI strobe |
| act_prio | output | 32 | Active-priorities vector |

## Verification
The bench builds the block with its default parameters: four list entries, 10-bit IDs and 5-bit priorities. With these values the spurious code is the all-ones ID 1023 and `act_prio` spans 32 levels. Four entries are enough for two equal-priority entries to test the tie-break, for a cross-group nesting two deep with a wrong-group EOI in between, and for out-of-order deactivation under mode 1. The 5-bit priority lets the bench check single bits such as 4, 10, 16 and 20 in `act_prio` directly.

// File: rtl/virq_pkg.sv
package virq_pkg;
    parameter int ID_W   = 10;
    parameter int PRIO_W = 5;
    localparam int NPRIO = 1 << PRIO_W;
    localparam logic [ID_W-1:0] SPUR_ID = '1;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              grp;
        logic              pend;
        logic              act;
        logic              hw;
        logic [ID_W-1:0]   pid;
    } lr_t;

    // bit 2 selects the group for the per-group registers
    typedef enum logic [2:0] {
        SEL_ACK0 = 3'b000,
        SEL_EOI0 = 3'b001,
        SEL_HPP0 = 3'b010,
        SEL_DIR  = 3'b011,
        SEL_ACK1 = 3'b100,
        SEL_EOI1 = 3'b101,
        SEL_HPP1 = 3'b110,
        SEL_RSVD = 3'b111
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_EOI, ST_HPP, ST_DIR
    } st_e;
endpackage

// File: rtl/virq_pick.sv
module virq_pick
    import virq_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  lr_t [N-1:0]       ents,
    input  logic              grp,
    output logic              found,
    output logic [IW-1:0]     idx,
    output logic [PRIO_W-1:0] prio
);
    // lowest priority value wins, strict compare keeps the lowest index on ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '1;
        for (int i = 0; i < N; i++) begin
            if (ents[i].pend && (ents[i].grp == grp) &&
                (!found || (ents[i].prio < prio))) begin
                found = 1'b1;
                idx   = IW'(i);
                prio  = ents[i].prio;
            end
        end
    end
endmodule

// File: rtl/virq_stack.sv
module virq_stack
    import virq_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1),
    localparam int DEPTH = 1 << CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IW-1:0]     push_idx,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              push_grp,
    input  logic              pop,
    output logic              empty,
    output logic [IW-1:0]     top_idx,
    output logic [PRIO_W-1:0] top_prio,
    output logic              top_grp
);
    logic [IW-1:0]     idx_m  [DEPTH];
    logic [PRIO_W-1:0] prio_m [DEPTH];
    logic              grp_m  [DEPTH];
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     top_p;

    assign empty    = (cnt == '0);
    assign top_p    = empty ? '0 : cnt - 1'b1;
    assign top_idx  = idx_m[top_p];
    assign top_prio = prio_m[top_p];
    assign top_grp  = grp_m[top_p];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                idx_m[i]  <= '0;
                prio_m[i] <= '0;
                grp_m[i]  <= 1'b0;
            end
        end else if (push && (cnt < CW'(N))) begin
            idx_m[cnt]  <= push_idx;
            prio_m[cnt] <= push_prio;
            grp_m[cnt]  <= push_grp;
            cnt         <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/virq_cpu_if.sv
module virq_cpu_if
    import virq_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int HW = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoi_mode,
    input  logic              lr_we,
    input  logic [IW-1:0]     lr_idx,
    input  logic [ID_W-1:0]   lr_id,
    input  logic [PRIO_W-1:0] lr_prio,
    input  logic              lr_grp,
    input  logic              lr_pend,
    input  logic              lr_act,
    input  logic              lr_hw,
    input  logic [ID_W-1:0]   lr_pid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_sel,
    input  logic [ID_W-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_data,
    output logic              pdeact_valid,
    output logic [ID_W-1:0]   pdeact_id,
    output logic              eoi_err,
    output logic [NPRIO-1:0]  act_prio
);
    st_e               state_q, state_d;
    logic              grp_q;
    logic [ID_W-1:0]   wdata_q;
    lr_t [NUM_ENT-1:0] ents;

    logic [1:0]        pk_found;
    logic [IW-1:0]     pk_idx  [2];
    logic [PRIO_W-1:0] pk_prio [2];

    for (genvar g = 0; g < 2; g++) begin : g_pick
        virq_pick #(.N(NUM_ENT)) u_pick (
            .ents  (ents),
            .grp   (g[0]),
            .found (pk_found[g]),
            .idx   (pk_idx[g]),
            .prio  (pk_prio[g])
        );
    end

    // lowest set index of the active vector; NPRIO when none is set
    logic [HW-1:0] hi_act;
    always_comb begin
        hi_act = HW'(NPRIO);
        for (int i = NPRIO - 1; i >= 0; i--)
            if (act_prio[i]) hi_act = HW'(i);
    end

    logic ack_ok, eoi_ok, dir_hit;
    logic [IW-1:0] dir_idx;
    logic st_empty, st_grp;
    logic [IW-1:0] st_idx;
    logic [PRIO_W-1:0] st_prio;

    assign ack_ok = pk_found[grp_q]
                 && !(pk_found[!grp_q] && (pk_prio[!grp_q] < pk_prio[grp_q]))
                 && ({1'b0, pk_prio[grp_q]} < hi_act);
    assign eoi_ok = !st_empty && (st_grp == grp_q)
                 && (ents[st_idx].id == wdata_q) && act_prio[st_prio];

    always_comb begin
        dir_hit = 1'b0;
        dir_idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!dir_hit && ents[i].act && (ents[i].id == wdata_q)) begin
                dir_hit = 1'b1;
                dir_idx = IW'(i);
            end
        end
    end

    virq_stack #(.N(NUM_ENT)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      ((state_q == ST_ACK) && ack_ok),
        .push_idx  (pk_idx[grp_q]),
        .push_prio (pk_prio[grp_q]),
        .push_grp  (grp_q),
        .pop       ((state_q == ST_EOI) && eoi_ok),
        .empty     (st_empty),
        .top_idx   (st_idx),
        .top_prio  (st_prio),
        .top_grp   (st_grp)
    );

    assign req_ready = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (sel_e'(req_sel))
                        SEL_ACK0, SEL_ACK1: state_d = ST_ACK;
                        SEL_EOI0, SEL_EOI1: state_d = ST_EOI;
                        SEL_HPP0, SEL_HPP1: state_d = ST_HPP;
                        SEL_DIR:            state_d = ST_DIR;
                        default:            state_d = ST_IDLE;
                    endcase
                end
            end
            ST_ACK, ST_EOI, ST_HPP, ST_DIR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and list state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents         <= '0;
            act_prio     <= '0;
            grp_q        <= 1'b0;
            wdata_q      <= '0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            pdeact_valid <= 1'b0;
            pdeact_id    <= '0;
            eoi_err      <= 1'b0;
        end else begin
            rsp_valid    <= 1'b0;
            pdeact_valid <= 1'b0;
            eoi_err      <= 1'b0;
            if ((state_q == ST_IDLE) && req_valid) begin
                grp_q   <= req_sel[2];
                wdata_q <= req_wdata;
            end
            if (lr_we) begin
                ents[lr_idx] <= '{id: lr_id, prio: lr_prio, grp: lr_grp,
                                  pend: lr_pend, act: lr_act, hw: lr_hw,
                                  pid: lr_pid};
            end
            unique case (state_q)
                ST_ACK: begin
                    rsp_valid <= 1'b1;
                    if (ack_ok) begin
                        rsp_data                   <= ents[pk_idx[grp_q]].id;
                        ents[pk_idx[grp_q]].pend   <= 1'b0;
                        ents[pk_idx[grp_q]].act    <= 1'b1;
                        act_prio[pk_prio[grp_q]]   <= 1'b1;
                    end else begin
                        rsp_data <= SPUR_ID;
                    end
                end
                ST_HPP: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= pk_found[grp_q] ? ents[pk_idx[grp_q]].id : SPUR_ID;
                end
                ST_EOI: begin
                    if (eoi_ok) begin
                        act_prio[st_prio] <= 1'b0;
                        if (!eoi_mode) begin
                            ents[st_idx].act <= 1'b0;
                            if (ents[st_idx].hw) begin
                                pdeact_valid <= 1'b1;
                                pdeact_id    <= ents[st_idx].pid;
                            end
                        end
                    end else begin
                        eoi_err <= 1'b1;
                    end
                end
                ST_DIR: begin
                    if (eoi_mode && dir_hit) begin
                        ents[dir_idx].act <= 1'b0;
                        if (ents[dir_idx].hw) begin
                            pdeact_valid <= 1'b1;
                            pdeact_id    <= ents[dir_idx].pid;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/virq_chk.sv
module virq_chk
    import virq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input st_e              state_q,
    input logic [NPRIO-1:0] act_prio,
    input logic             rsp_valid,
    input logic [ID_W-1:0]  rsp_data,
    input logic             pdeact_valid,
    input logic             eoi_err
);
    assert_ack_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ($past(state_q) == ST_ACK) && (rsp_data != SPUR_ID))
        |-> ($countones(act_prio) == $countones($past(act_prio)) + 1));

    assert_spurious_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && ($past(state_q) == ST_ACK) && (rsp_data == SPUR_ID))
        |-> (act_prio == $past(act_prio)));

    assert_hpp_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HPP) |-> (act_prio == $past(act_prio)));

    assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_EOI) && !eoi_err)
        |-> ($countones(act_prio) + 1 == $countones($past(act_prio))));

    assert_pdeact_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pdeact_valid |=> !pdeact_valid);

    assert_err_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |-> (act_prio == $past(act_prio)));
endmodule

bind virq_cpu_if virq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .act_prio     (act_prio),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .pdeact_valid (pdeact_valid),
    .eoi_err      (eoi_err)
);

// File: tb/tb_virq_cpu_if.sv
module tb_virq_cpu_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoi_mode = 1'b0;
    logic        lr_we = 1'b0;
    logic [1:0]  lr_idx = '0;
    logic [9:0]  lr_id = '0;
    logic [4:0]  lr_prio = '0;
    logic        lr_grp = 1'b0, lr_pend = 1'b0, lr_act = 1'b0, lr_hw = 1'b0;
    logic [9:0]  lr_pid = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_sel = '0;
    logic [9:0]  req_wdata = '0;
    logic        rsp_valid, pdeact_valid, eoi_err;
    logic [9:0]  rsp_data, pdeact_id;
    logic [31:0] act_prio;

    int n_run = 0;
    int n_fail = 0;

    logic        s_valid, s_pd, s_err;
    logic [9:0]  s_data, s_pdid;

    localparam logic [2:0] ACK0 = 3'b000, EOI0 = 3'b001, HPP0 = 3'b010, DIR = 3'b011;
    localparam logic [2:0] ACK1 = 3'b100, EOI1 = 3'b101, HPP1 = 3'b110;

    always #5 clk = ~clk;

    virq_cpu_if dut (
        .clk(clk), .rst_n(rst_n), .eoi_mode(eoi_mode),
        .lr_we(lr_we), .lr_idx(lr_idx), .lr_id(lr_id), .lr_prio(lr_prio),
        .lr_grp(lr_grp), .lr_pend(lr_pend), .lr_act(lr_act), .lr_hw(lr_hw),
        .lr_pid(lr_pid), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pdeact_valid(pdeact_valid), .pdeact_id(pdeact_id),
        .eoi_err(eoi_err), .act_prio(act_prio)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input int id, input int prio, input bit grp,
                        input bit hw, input int pid);
        @(negedge clk);
        lr_we = 1'b1; lr_idx = 2'(idx); lr_id = 10'(id); lr_prio = 5'(prio);
        lr_grp = grp; lr_pend = 1'b1; lr_act = 1'b0; lr_hw = hw; lr_pid = 10'(pid);
        @(negedge clk);
        lr_we = 1'b0;
    endtask

    // request at a falling edge, sample two falling edges later
    task automatic reg_op(input logic [2:0] sel, input int wdata);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_wdata = 10'(wdata);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        s_valid = rsp_valid; s_data = rsp_data;
        s_pd = pdeact_valid; s_pdid = pdeact_id; s_err = eoi_err;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "act_prio", act_prio, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "pdeact_valid", pdeact_valid, 0);
        chk("R1", "eoi_err", eoi_err, 0);
        chk("R1", "req_ready", req_ready, 1);
    endtask

    task automatic t_empty;
        reg_op(ACK0, 0);
        chk("R3", "ack empty valid", s_valid, 1);
        chk("R3", "ack empty id", s_data, 1023);
        reg_op(HPP1, 0);
        chk("R6", "hpp empty id", s_data, 1023);
        reg_op(EOI0, 5);
        chk("R11", "eoi nothing active", s_err, 1);
        reg_op(3'b111, 0);
        chk("R12", "reserved select no response", s_valid, 0);
    endtask

    task automatic t_basic;
        eoi_mode = 1'b0;
        load(0, 40, 10, 0, 0, 0);
        load(1, 41, 10, 0, 0, 0);
        load(2, 50, 20, 1, 1, 300);
        reg_op(HPP0, 0);
        chk("R6", "hpp tie lowest index", s_data, 40);
        chk("R6", "hpp no state change", act_prio, 0);
        reg_op(ACK1, 0);
        chk("R4", "other group higher", s_data, 1023);
        reg_op(ACK0, 0);
        chk("R2", "ack id", s_data, 40);
        chk("R2", "ack sets prio bit", act_prio, 32'h1 << 10);
        reg_op(ACK0, 0);
        chk("R5", "equal prio no preempt", s_data, 1023);
        reg_op(EOI1, 40);
        chk("R11", "wrong group err", s_err, 1);
        chk("R11", "wrong group act_prio", act_prio, 32'h1 << 10);
        reg_op(EOI0, 40);
        chk("R7", "eoi drop", act_prio, 0);
        chk("R8", "sw entry no pdeact", s_pd, 0);
        reg_op(ACK0, 0);
        chk("R2", "second ack", s_data, 41);
        reg_op(ACK1, 0);
        chk("R5", "lower prio blocked", s_data, 1023);
        reg_op(EOI0, 41);
        chk("R7", "eoi drop 41", act_prio, 0);
        reg_op(ACK1, 0);
        chk("R2", "ack group1", s_data, 50);
        chk("R2", "ack group1 bit", act_prio, 32'h1 << 20);
        reg_op(EOI1, 50);
        chk("R8", "hw pdeact valid", s_pd, 1);
        chk("R8", "hw pdeact id", s_pdid, 300);
        chk("R7", "drop group1", act_prio, 0);
    endtask

    task automatic t_nested;
        eoi_mode = 1'b0;
        load(0, 60, 16, 0, 0, 0);
        reg_op(ACK0, 0);
        chk("R2", "outer ack", s_data, 60);
        load(1, 61, 4, 1, 1, 500);
        reg_op(ACK1, 0);
        chk("R5", "preempt ack", s_data, 61);
        chk("R2", "two bits", act_prio, (32'h1 << 16) | (32'h1 << 4));
        reg_op(EOI0, 60);
        chk("R11", "out of order eoi err", s_err, 1);
        reg_op(EOI1, 99);
        chk("R11", "id mismatch err", s_err, 1);
        chk("R11", "mismatch keeps bits", act_prio, (32'h1 << 16) | (32'h1 << 4));
        reg_op(EOI1, 61);
        chk("R7", "inner drop", act_prio, 32'h1 << 16);
        chk("R8", "inner pdeact id", s_pdid, 500);
        reg_op(EOI0, 60);
        chk("R7", "outer drop", act_prio, 0);
        chk("R7", "outer accepted", s_err, 0);
    endtask

    task automatic t_mode1;
        eoi_mode = 1'b1;
        load(0, 70, 8, 0, 1, 700);
        reg_op(ACK0, 0);
        chk("R2", "mode1 ack0", s_data, 70);
        load(1, 71, 2, 1, 1, 701);
        reg_op(ACK1, 0);
        chk("R2", "mode1 ack1", s_data, 71);
        reg_op(EOI1, 71);
        chk("R9", "drop only no pdeact", s_pd, 0);
        chk("R9", "drop bit", act_prio, 32'h1 << 8);
        reg_op(EOI0, 70);
        chk("R9", "drop only no pdeact 70", s_pd, 0);
        chk("R9", "all dropped", act_prio, 0);
        reg_op(DIR, 70);
        chk("R10", "dir 70 pulse", s_pd, 1);
        chk("R10", "dir 70 pid", s_pdid, 700);
        reg_op(DIR, 71);
        chk("R10", "dir 71 pid", s_pdid, 701);
        reg_op(DIR, 71);
        chk("R10", "dir inactive no pulse", s_pd, 0);
        eoi_mode = 1'b0;
        load(2, 80, 3, 0, 1, 800);
        reg_op(ACK0, 0);
        chk("R12", "ack0 code", s_data, 80);
        reg_op(DIR, 80);
        chk("R10", "dir ignored in mode0", s_pd, 0);
        reg_op(EOI0, 80);
        chk("R8", "entry still active then eoi", s_pd, 1);
        chk("R8", "eoi pid", s_pdid, 800);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R0 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty();
        t_basic();
        t_nested();
        t_mode1();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule